// File: doc/BRIEF.md
# Instruction Extension Fetch Sequencer

This block reads one instruction from a 16-bit big-endian program memory. The memory holds instructions in the classic 16-bit two-address encoding. Given a start address, the block reads the opcode word. It then reads only the extension words that the opcode calls for. These can be a 16-bit branch displacement, an absolute address, an immediate word, or an index extension word. An index extension word in full format can bring a base displacement and an outer displacement, and each of these can be one word or a long.

When the last word has been read, the block pulses `done` and holds its results until the next start. The results are the opcode, up to two assembled 32-bit displacements, the instruction length in bytes, and three indications: illegal encoding, unimplemented line, and address fault. A prefetch or decode stage uses it to find the boundary of the next instruction and to collect its extension data. The stage does this without decoding the operation itself.

Top module: `insn_fetch_seq`

## Requirements
- R1: After reset the sequencer is idle. `mem_req` and `done` are low, and `opcode`, `disp_a`, `disp_b`, `ins_len` and all three flags are zero.
- R2: Every word is read at the current fetch address, which starts at `start_pc` and advances by 2 after each acknowledged read. While a read waits for `mem_ack`, `mem_req` stays high and `mem_addr` is stable. A 32-bit value is read as two words, the high word first, so the address advances by 4.
- R3: An odd `start_pc` issues no memory read. It completes with `addr_err` = 1 and `ins_len` = 0.
- R4: An opcode whose bits 15:12 are 0xA or 0xF sets `line_trap`. No further word is read, so `ins_len` = 2.
- R5: An opcode with bits 15:12 = 0x7 reads no extension. If bit 8 is set it flags `illegal`. Otherwise `disp_a` is the sign-extended low byte.
- R6: An opcode with bits 15:12 = 0x6 and a nonzero low byte gives `disp_a` = that byte sign-extended, with `ins_len` = 2.
- R7: An opcode with bits 15:12 = 0x6 and a zero low byte reads one more word. `disp_a` is that word sign-extended, and `ins_len` = 4.
- R8: For every other opcode, bits 5:3 give a mode and bits 2:0 give a register.
  - Modes 000 to 100 read no extension.
  - Mode 101 reads one word.
  - Mode 111 with register 000, 010 or 100 reads one word. With register 001 it reads a long.
  - Any of these reads loads `disp_a`, a word being sign-extended.
  - Mode 111 with registers 101 to 111 flags `illegal` after the opcode only.
- R9: Mode 110, and mode 111 with register 011, read an index extension word. If its bit 8 is clear (brief form), `disp_a` is its low byte sign-extended, `disp_b` = 0, and nothing more is read.
- R10: If bit 8 of the index word is set (full form), bits 5:4 select the base displacement into `disp_a` and then bits 1:0 select the outer displacement into `disp_b`. For each selector:
  - 00 or 01 gives zero and reads nothing.
  - 10 reads one word, sign-extended.
  - 11 reads a long.
- R11: `done` is a one-cycle pulse. `ins_len` equals the number of bytes read, and all results hold until the next accepted start.
- R12: A `start` that arrives while a fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (accepted only when idle) |
| start_pc | input | AW | Address of the opcode word |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Word read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 16 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| opcode | output | 16 | Captured opcode word |
| disp_a | output | 32 | Branch, absolute, immediate, brief or base displacement |
| disp_b | output | 32 | Outer displacement |
| ins_len | output | LW | Instruction length in bytes |
| illegal | output | 1 | Illegal encoding |
| line_trap | output | 1 | Unimplemented-line opcode |
| addr_err | output | 1 | Odd start address |

## Verification
The embedded properties check the memory handshake on every cycle. They check that a pending request holds its address, that each acknowledged read advances the address by exactly 2, and that every request address is even. At completion they check that lengths are even and bounded, that a fault reports zero bytes, and that a line or quick-move outcome reports a two-byte length.

Only the bench's sweeps can show that the right number of words is read for each opcode and index word, and that the displacements are assembled and sign-extended correctly. The sweeps cover all 64 operand fields, all 256 branch bytes and all 16 full-form selector pairs. The sweeps also show that a start arriving mid-fetch leaves the result untouched.

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq #(
  parameter int AW = 32,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_pc,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          done,
  output logic [15:0]   opcode,
  output logic [31:0]   disp_a,
  output logic [31:0]   disp_b,
  output logic [LW-1:0] ins_len,
  output logic          illegal,
  output logic          line_trap,
  output logic          addr_err
);
  localparam int MAXB = 12;

  typedef enum logic [2:0] {S_IDLE, S_OP, S_IDX, S_WORD, S_HI, S_LO} st_t;
  st_t         st;
  logic [AW-1:0] fa;
  logic        tgt_b;
  logic [1:0]  osel;
  logic [15:0] hi;

  assign mem_req  = (st != S_IDLE);
  assign mem_addr = fa;

  wire        take = mem_req && mem_ack;
  wire [31:0] sx8  = {{24{mem_rdata[7]}}, mem_rdata[7:0]};
  wire [31:0] sx16 = {{16{mem_rdata[15]}}, mem_rdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fa <= '0; tgt_b <= 1'b0; osel <= 2'b00; hi <= '0;
      done <= 1'b0; opcode <= '0; disp_a <= '0; disp_b <= '0; ins_len <= '0;
      illegal <= 1'b0; line_trap <= 1'b0; addr_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        fa <= fa + AW'(2);
        ins_len <= ins_len + LW'(2);
      end
      case (st)
        S_IDLE: if (start) begin
          opcode <= '0; disp_a <= '0; disp_b <= '0; ins_len <= '0;
          illegal <= 1'b0; line_trap <= 1'b0; addr_err <= 1'b0;
          fa <= start_pc; tgt_b <= 1'b0; osel <= 2'b00;
          if (start_pc[0]) begin
            addr_err <= 1'b1;
            done <= 1'b1;
          end else st <= S_OP;
        end
        S_OP: if (take) begin
          opcode <= mem_rdata;
          if (mem_rdata[15:12] == 4'hA || mem_rdata[15:12] == 4'hF) begin
            line_trap <= 1'b1; st <= S_IDLE; done <= 1'b1;
          end else if (mem_rdata[15:12] == 4'h7) begin
            if (mem_rdata[8]) illegal <= 1'b1;
            else disp_a <= sx8;
            st <= S_IDLE; done <= 1'b1;
          end else if (mem_rdata[15:12] == 4'h6) begin
            if (mem_rdata[7:0] != 8'h00) begin
              disp_a <= sx8; st <= S_IDLE; done <= 1'b1;
            end else st <= S_WORD;
          end else begin
            case (mem_rdata[5:3])
              3'b101: st <= S_WORD;
              3'b110: st <= S_IDX;
              3'b111: case (mem_rdata[2:0])
                3'b000, 3'b010, 3'b100: st <= S_WORD;
                3'b001:                 st <= S_HI;
                3'b011:                 st <= S_IDX;
                default: begin illegal <= 1'b1; st <= S_IDLE; done <= 1'b1; end
              endcase
              default: begin st <= S_IDLE; done <= 1'b1; end
            endcase
          end
        end
        S_IDX: if (take) begin
          if (!mem_rdata[8]) begin
            disp_a <= sx8; st <= S_IDLE; done <= 1'b1;
          end else begin
            osel <= mem_rdata[1:0];
            if (mem_rdata[5]) begin
              tgt_b <= 1'b0;
              st <= mem_rdata[4] ? S_HI : S_WORD;
            end else if (mem_rdata[1]) begin
              tgt_b <= 1'b1;
              st <= mem_rdata[0] ? S_HI : S_WORD;
            end else begin
              st <= S_IDLE; done <= 1'b1;
            end
          end
        end
        S_HI: if (take) begin
          hi <= mem_rdata;
          st <= S_LO;
        end
        S_WORD, S_LO: if (take) begin
          if (tgt_b) disp_b <= (st == S_LO) ? {hi, mem_rdata} : sx16;
          else       disp_a <= (st == S_LO) ? {hi, mem_rdata} : sx16;
          if (!tgt_b && osel[1]) begin
            tgt_b <= 1'b1;
            st <= osel[0] ? S_HI : S_WORD;
          end else begin
            st <= S_IDLE; done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> (mem_req -> mem_addr == $past(mem_addr) + AW'(2)));
  a_r2_even: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
  a_r3_fault_len: assert property (@(posedge clk) disable iff (!rst_n)
    done && addr_err |-> ins_len == '0);
  a_r4_line_len: assert property (@(posedge clk) disable iff (!rst_n)
    done && line_trap |-> ins_len == LW'(2));
  a_r5_quick_len: assert property (@(posedge clk) disable iff (!rst_n)
    done && opcode[15:12] == 4'h7 |-> ins_len == LW'(2));
  a_r11_len_ok: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ins_len[0] && int'(ins_len) <= MAXB);
endmodule

// File: tb/sim_insn_fetch_seq.sv
module sim_insn_fetch_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] start_pc = '0;
  logic mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic done, illegal, line_trap, addr_err;
  logic [15:0] opcode;
  logic [31:0] disp_a, disp_b;
  logic [3:0] ins_len;

  always #2 clk = ~clk;

  insn_fetch_seq #(.AW(32), .LW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .opcode(opcode), .disp_a(disp_a), .disp_b(disp_b),
    .ins_len(ins_len), .illegal(illegal), .line_trap(line_trap), .addr_err(addr_err));

  int n_tests = 0, n_fail = 0;
  logic [15:0] w [0:15];
  logic [31:0] cur_pc = '0;
  int lat = 0, wait_cnt = 0, n_ack = 0, addr_bad = 0, req_cycles = 0;

  int e_len, e_ill, e_lt, e_ae;
  logic [31:0] e_da, e_db;
  logic [15:0] e_op;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h (op %h pc %h)", req, got, exp, w[0], cur_pc);
    end
  endtask

  function automatic logic [31:0] s8(input logic [15:0] x);
    return {{24{x[7]}}, x[7:0]};
  endfunction
  function automatic logic [31:0] s16(input logic [15:0] x);
    return {{16{x[15]}}, x};
  endfunction

  task automatic get_disp(input logic [1:0] sel, inout int k, output logic [31:0] v);
    v = '0;
    if (sel == 2'b10) begin v = s16(w[k]); k++; end
    else if (sel == 2'b11) begin v = {w[k], w[k+1]}; k += 2; end
  endtask

  task automatic model(input logic odd);
    int k;
    logic [15:0] op, x;
    logic idx;
    e_da = '0; e_db = '0; e_ill = 0; e_lt = 0; e_ae = 0; e_op = '0;
    if (odd) begin e_ae = 1; e_len = 0; return; end
    op = w[0]; e_op = op; k = 1; idx = 1'b0;
    if (op[15:12] == 4'hA || op[15:12] == 4'hF) e_lt = 1;
    else if (op[15:12] == 4'h7) begin
      if (op[8]) e_ill = 1; else e_da = s8(op);
    end else if (op[15:12] == 4'h6) begin
      if (op[7:0] != 0) e_da = s8(op);
      else begin e_da = s16(w[1]); k = 2; end
    end else begin
      case (op[5:3])
        3'd5: begin e_da = s16(w[k]); k++; end
        3'd6: idx = 1'b1;
        3'd7: case (op[2:0])
          3'd0, 3'd2, 3'd4: begin e_da = s16(w[k]); k++; end
          3'd1: begin e_da = {w[k], w[k+1]}; k += 2; end
          3'd3: idx = 1'b1;
          default: e_ill = 1;
        endcase
        default: ;
      endcase
      if (idx) begin
        x = w[k]; k++;
        if (!x[8]) e_da = s8(x);
        else begin
          get_disp(x[5:4], k, e_da);
          get_disp(x[1:0], k, e_db);
        end
      end
    end
    e_len = 2 * k;
  endtask

  task automatic run(input logic [31:0] pc, input int l, input bit poke);
    int t;
    cur_pc = pc; lat = l; n_ack = 0; addr_bad = 0; req_cycles = 0; wait_cnt = 0;
    model(pc[0]);
    @(negedge clk); start = 1'b1; start_pc = pc;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 200) begin
      if (poke && t == 2) begin start = 1'b1; start_pc = pc + 32'd1; end
      else start = 1'b0;
      @(negedge clk); t++;
    end
    start = 1'b0;
    if (t >= 200) chk("R11 watchdog", 32'd1, 32'd0);
    chk("R11 len", 32'(ins_len), 32'(e_len));
    chk("R11 acks", 32'(2 * n_ack), 32'(e_len));
    chk("R2 addr", 32'(addr_bad), 32'd0);
    chk("R8 opcode", 32'(opcode), 32'(e_op));
    chk("R10 disp_a", disp_a, e_da);
    chk("R10 disp_b", disp_b, e_db);
    chk("R5 illegal", 32'(illegal), 32'(e_ill));
    chk("R4 line_trap", 32'(line_trap), 32'(e_lt));
    chk("R3 addr_err", 32'(addr_err), 32'(e_ae));
    if (e_ae != 0) chk("R3 no read", 32'(req_cycles), 32'd0);
    if (poke) chk("R12 busy start ignored", 32'(addr_err), 32'd0);
    @(negedge clk);
    chk("R11 pulse", 32'(done), 32'd0);
    chk("R11 hold", 32'(ins_len), 32'(e_len));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) w[i] = 16'h0;
    fork
      forever begin
        @(negedge clk);
        if (mem_req) begin
          req_cycles++;
          if (wait_cnt >= lat) begin
            if (mem_addr != cur_pc + 32'(2 * n_ack)) addr_bad++;
            mem_ack = 1'b1;
            mem_rdata = (((mem_addr - cur_pc) >> 1) < 16) ? w[(mem_addr - cur_pc) >> 1] : 16'h0;
            n_ack++;
            wait_cnt = 0;
          end else begin
            mem_ack = 1'b0;
            wait_cnt++;
          end
        end else begin
          mem_ack = 1'b0;
          wait_cnt = 0;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 len", 32'(ins_len), 32'd0);
    chk("R1 disp", disp_a | disp_b, 32'd0);
    chk("R1 flags", 32'({illegal, line_trap, addr_err}), 32'd0);

    // R8 and R9: every operand field, brief index word and assorted extensions
    for (int ea = 0; ea < 64; ea++) begin
      w[0] = 16'h3000 | 16'(ea);
      w[1] = 16'h8E85; w[2] = 16'hFFFE; w[3] = 16'h1357; w[4] = 16'h2468;
      run(32'h2000 + 32'(2 * (ea % 8)), ea % 3, 1'b0);
    end
    // R10: all full-form selector pairs, register and program-counter based
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 4; o++)
        for (int m = 0; m < 2; m++) begin
          w[0] = (m == 0) ? 16'h4030 : 16'h203B;
          w[1] = 16'h0100 | 16'(b << 4) | 16'(o);
          w[2] = 16'h8001; w[3] = 16'h1234; w[4] = 16'hF678; w[5] = 16'h9ABC;
          run(32'h3000 + 32'(4 * b), (b + o) % 3, 1'b0);
        end
    // R6 and R7: every branch displacement byte
    for (int d = 0; d < 256; d++) begin
      w[0] = 16'h6100 | 16'(d);
      w[1] = (d % 2 == 0) ? 16'h8123 : 16'h0456;
      run(32'h4000, d % 2, 1'b0);
    end
    // R4 and R5: line opcodes and quick moves
    for (int v = 0; v < 16; v++) begin
      w[0] = 16'hA000 | 16'(v * 17);   run(32'h5000, v % 3, 1'b0);
      w[0] = 16'hF03B | 16'(v << 8);   run(32'h5002, 0, 1'b0);
      w[0] = 16'h7000 | 16'(v * 37) | 16'((v % 2) << 8); run(32'h5004, 1, 1'b0);
    end
    // R3: odd start address
    w[0] = 16'h3039;
    run(32'h6001, 0, 1'b0);
    run(32'h6FFF, 2, 1'b0);
    // R12: start pulse during a long fetch
    w[0] = 16'h4030; w[1] = 16'h0133; w[2] = 16'h1111; w[3] = 16'h2222;
    w[4] = 16'h3333; w[5] = 16'h4444;
    run(32'h7000, 2, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule